// File: doc/BRIEF.md
# Byte-Wide SPI Master

This block is a serial peripheral interface master that moves exactly one byte per command. Software configures it through a handful of byte registers on a simple synchronous CPU bus. It then loads a byte to send and writes a start bit. The block shifts that byte out on `mosi` while it collects one byte from `miso`. When the eighth bit has been captured, it latches the received byte, raises a ready flag and asserts `irq`.

There is no queue. Every byte costs one start command and one interrupt, and software reloads the send register between bytes. Clock idle level, sampling phase and bit order are programmable, and all four standard SPI modes are covered. An internal loopback path feeds the shifter's own serial output back into its serial input, which allows a self-test without a slave. The serial clock runs at the bus clock divided by 4·(divisor+1), where the divisor is an 8-bit register. Chip selects are handled outside this block.

Top module: `spi_byte_master`

## Requirements
- R1: Register offsets are: control/mode at 2'd0+0 (offset 0), received byte at 1, send byte at 2, command at 3, status at 4 and divisor at 6. The mode register keeps only bits 4..0 and reads back with its upper bits zero. The send byte and the divisor read back as written. Offsets 3 and 5 read as zero.
- R2: Writing a command with bit 0 set starts a transfer only when mode bit 3 (port enable) is 1 and no transfer is in progress. In any other case the command changes nothing: no serial clock edges are produced and status bit 1 stays 0.
- R3: During a transfer `sck` produces 8 full periods. Each period is 4·(D+1) bus clocks, where D is the divisor register (0..255). Outside a transfer `sck` sits at the level given by mode bit 1 (1 = idle high).
- R4: Mode bit 4 selects the sampling edge. When it is 1, both sides sample on the leading edge of each `sck` period and `mosi` changes on the trailing edge, with the first bit driven at the start. When it is 0, `mosi` changes on the leading edge and sampling happens on the trailing edge. The four modes 0..3 map to (bit 4, bit 1) = (1,0), (0,0), (1,1), (0,1).
- R5: Mode bit 2 set sends and assembles the byte least significant bit first. When it is clear, the most significant bit goes first.
- R6: Mode bit 2'b0 + bit 0 (loopback) set makes the shifter capture its own `mosi` output. `miso` is then ignored, and the received byte equals the byte that was sent.
- R7: At the end of a transfer, status bit 0 (receive ready) and `irq` rise together. Status bit 1 (busy) is still 1 in that first cycle and reads 0 in the next cycle.
- R8: Reading offset 1 with the read strobe clears receive ready and `irq`. An accepted start also clears them.
- R9: After reset all registers are zero, `irq` is 0, and `sck` and `mosi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_rd | input | 1 | Read strobe, valid with bus_sel |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Byte-complete interrupt, level |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume a few things about the software and the slave. Software changes the divisor only while no transfer is running. Bus strobes last one cycle per access. `miso` is steady at every sampling edge, because the slave only changes it on the opposite edge. The bench respects all three. It writes the divisor and mode only between bytes. Its tasks drive each strobe for a single cycle, away from the clock edge. Its slave model updates `miso` only on its own shift edge, derived from the same mode settings the bench programmed. The one deliberate exception is a start issued while busy; it probes R2 and must leave the running transfer untouched.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] OFS_MODE = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_RXB  = 3'd1;
   localparam logic [ADDR_W-1:0] OFS_TXB  = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
   localparam logic [ADDR_W-1:0] OFS_DIV  = 3'd6;

   localparam int CMD_GO_BIT   = 0;
   localparam int STAT_RDY_BIT = 0;
   localparam int STAT_BSY_BIT = 1;

   // field order matches the bit positions software writes (bit 4 down to bit 0)
   typedef struct packed {
      logic early;    // sample on leading edge
      logic en;       // port enable
      logic lsb;      // least significant bit first
      logic idle_hi;  // clock idle level
      logic loop;     // internal loopback
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_FIN,
      ST_HOLD
   } eng_st_t;
endpackage

// File: rtl/sbm_regs.sv
module sbm_regs
   import sbm_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output mode_t             mode,
   output logic [DW-1:0]     tx_byte,
   output logic [DIV_W-1:0]  cdm,
   output logic              start_go,
   output logic              rx_rdy,
   input  logic              busy,
   input  logic              done,
   input  logic [DW-1:0]     rx_byte
);
   localparam int STAT_W = 2;

   if (DW < MODE_W) begin : g_chk_dw
      $error("sbm_regs: DW must hold the mode field");
   end
   if (DIV_W > DW) begin : g_chk_div
      $error("sbm_regs: DIV_W must not exceed DW");
   end

   logic          wr_mode, wr_txb, wr_div, wr_cmd, rx_rd;
   logic [DW-1:0] rxb_q;

   assign wr_mode  = bus_sel && bus_wr && (bus_addr == OFS_MODE);
   assign wr_txb   = bus_sel && bus_wr && (bus_addr == OFS_TXB);
   assign wr_div   = bus_sel && bus_wr && (bus_addr == OFS_DIV);
   assign wr_cmd   = bus_sel && bus_wr && (bus_addr == OFS_CMD) && bus_wdata[CMD_GO_BIT];
   assign rx_rd    = bus_sel && bus_rd && (bus_addr == OFS_RXB);
   assign start_go = wr_cmd && mode.en && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= '0;
         tx_byte <= '0;
         cdm     <= '0;
      end else begin
         if (wr_mode) mode    <= mode_t'(bus_wdata[MODE_W-1:0]);
         if (wr_txb)  tx_byte <= bus_wdata;
         if (wr_div)  cdm     <= bus_wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rxb_q  <= '0;
         rx_rdy <= 1'b0;
      end else if (done) begin
         rxb_q  <= rx_byte;
         rx_rdy <= 1'b1;
      end else if (start_go || rx_rd) begin
         rx_rdy <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_MODE: bus_rdata[MODE_W-1:0] = mode;
         OFS_RXB:  bus_rdata = rxb_q;
         OFS_TXB:  bus_rdata = tx_byte;
         OFS_STAT: begin
            bus_rdata[STAT_BSY_BIT] = busy;
            bus_rdata[STAT_RDY_BIT] = rx_rdy;
         end
         OFS_DIV:  bus_rdata[DIV_W-1:0] = cdm;
         default:  bus_rdata = '0;
      endcase
   end

   AST_RDY_SET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rx_rdy); // R7
   AST_RDY_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !done) |=> !rx_rdy); // R8
   AST_STAT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFS_STAT) |-> (bus_rdata[DW-1:STAT_W] == '0)); // R1
endmodule

// File: rtl/sbm_clkgen.sv
module sbm_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] cdm,
   output logic             tick
);
   localparam int CW = DIV_W + 1;

   if (DIV_W < 1 || DIV_W > 16) begin : g_chk_w
      $error("sbm_clkgen: DIV_W out of range");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] half_last;

   // half period is 2*(cdm+1) bus clocks, so the last count is 2*cdm+1
   assign half_last = {cdm, 1'b1};
   assign tick      = run && (cnt == half_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R3
endmodule

// File: rtl/sbm_shifter.sv
module sbm_shifter
   import sbm_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_go,
   input  logic [DW-1:0] tx_byte,
   input  mode_t         mode,
   input  logic          tick,
   input  logic          miso,
   output logic          busy,
   output logic          run,
   output logic          done,
   output logic [DW-1:0] rx_byte,
   output logic          sck,
   output logic          mosi
);
   localparam int EDGES = 2 * DW;
   localparam int EW    = $clog2(EDGES);

   if (DW < 2) begin : g_chk_dw
      $error("sbm_shifter: DW must be at least 2");
   end

   eng_st_t       st;
   logic [EW-1:0] edge_n;
   logic          ph_q, mosi_q;
   logic [DW-1:0] tx_sh, rx_sh;
   logic [DW-1:0] tx_rev, rx_rev, tx_ord;
   mode_t         ml;
   logic          lead_e, trail_e, shift_e, samp_e, sin, last_e;

   for (genvar gi = 0; gi < DW; gi++) begin : g_rev
      assign tx_rev[gi] = tx_byte[DW-1-gi];
      assign rx_rev[gi] = rx_sh[DW-1-gi];
   end

   assign tx_ord  = mode.lsb ? tx_rev : tx_byte;
   assign lead_e  = tick && !ph_q;
   assign trail_e = tick &&  ph_q;
   assign shift_e = ml.early ? trail_e : lead_e;
   assign samp_e  = ml.early ? lead_e  : trail_e;
   assign sin     = ml.loop ? mosi_q : miso;
   assign last_e  = (edge_n == EW'(EDGES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         edge_n <= '0;
         ph_q   <= 1'b0;
         mosi_q <= 1'b0;
         tx_sh  <= '0;
         rx_sh  <= '0;
         ml     <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start_go) begin
                  st     <= ST_RUN;
                  edge_n <= '0;
                  ph_q   <= 1'b0;
                  ml     <= mode;
                  rx_sh  <= '0;
                  if (mode.early) begin
                     mosi_q <= tx_ord[DW-1];
                     tx_sh  <= tx_ord << 1;
                  end else begin
                     tx_sh  <= tx_ord;
                  end
               end
            end
            ST_RUN: begin
               if (tick) begin
                  ph_q   <= !ph_q;
                  edge_n <= edge_n + 1'b1;
                  if (shift_e) begin
                     mosi_q <= tx_sh[DW-1];
                     tx_sh  <= tx_sh << 1;
                  end
                  if (samp_e) begin
                     rx_sh <= {rx_sh[DW-2:0], sin};
                  end
                  if (last_e) begin
                     st <= ST_FIN;
                  end
               end
            end
            ST_FIN:  st <= ST_HOLD;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign run     = (st == ST_RUN);
   assign done    = (st == ST_FIN);
   assign rx_byte = ml.lsb ? rx_rev : rx_sh;
   assign sck     = (busy ? ml.idle_hi : mode.idle_hi) ^ ph_q;
   assign mosi    = mosi_q;

   AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !ph_q); // R3
   AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && samp_e) |=> $stable(mosi)); // R4
   AST_RUN_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !done); // R7
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import sbm_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);
   mode_t            mode;
   logic [DW-1:0]    tx_byte, rx_byte;
   logic [DIV_W-1:0] cdm;
   logic             start_go, rx_rdy, busy, run, done, tick;

   sbm_regs #(.DW(DW), .DIV_W(DIV_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .mode      (mode),
      .tx_byte   (tx_byte),
      .cdm       (cdm),
      .start_go  (start_go),
      .rx_rdy    (rx_rdy),
      .busy      (busy),
      .done      (done),
      .rx_byte   (rx_byte)
   );

   sbm_clkgen #(.DIV_W(DIV_W)) clkgen_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .cdm   (cdm),
      .tick  (tick)
   );

   sbm_shifter #(.DW(DW)) shifter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_go (start_go),
      .tx_byte  (tx_byte),
      .mode     (mode),
      .tick     (tick),
      .miso     (miso),
      .busy     (busy),
      .run      (run),
      .done     (done),
      .rx_byte  (rx_byte),
      .sck      (sck),
      .mosi     (mosi)
   );

   assign irq = rx_rdy;

   AST_EN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mode.en)); // R2
   AST_IRQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> busy); // R7
   AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |=> !busy); // R7
endmodule

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] A_MODE = 3'd0, A_RXB = 3'd1, A_TXB = 3'd2,
                          A_CMD = 3'd3, A_STAT = 3'd4, A_GAP = 3'd5, A_DIV = 3'd6;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sel = 1'b0, wr = 1'b0, rd = 1'b0, miso = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq, sck, mosi;

   int     total = 0, bad = 0;
   longint cyc = 0;

   spi_byte_master dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rev8(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; rd = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      sel = 1'b0; rd = 1'b0;
   endtask

   // slave model and scoreboard monitor
   logic [7:0] exp_q[$];
   logic [7:0] slave_byte = '0, s_tx = '0, s_rx = '0;
   int         arm_cnt = 0, arm_seen = 0, samp_n = 0, lead_n = 0, exp_period = 4;
   bit         s_early = 1'b0, s_idle = 1'b0;
   longint     last_lead = 0;
   logic       prev_sck = 1'b0;

   always @(negedge clk) begin
      if (arm_seen != arm_cnt) begin
         arm_seen = arm_cnt;
         samp_n = 0; lead_n = 0; s_rx = '0;
         if (s_early) begin
            miso = slave_byte[7];
            s_tx = slave_byte << 1;
         end else begin
            s_tx = slave_byte;
         end
      end else if (rst_n && sck !== prev_sck) begin
         bit lead;
         lead = (sck != s_idle);
         if (lead) begin
            if (lead_n == 1)
               chk(cyc - last_lead == exp_period, "R3 sck period", cyc - last_lead, exp_period);
            last_lead = cyc;
            lead_n++;
         end
         if (lead == s_early) begin
            s_rx = {s_rx[6:0], mosi};
            samp_n++;
            if (samp_n == 8) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R2 unexpected byte on wire", s_rx, 0);
               end else begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  chk(s_rx == e, "R4 R5 wire byte seen by slave", s_rx, e);
               end
            end
         end else begin
            miso = s_tx[7];
            s_tx = s_tx << 1;
         end
      end
      prev_sck = sck;
   end

   task automatic xfer(input int md, input bit lsb, input bit loop, input int cdm,
                       input logic [7:0] tx, input logic [7:0] stx,
                       input bit poke, input bit keep);
      bit         early, idle;
      logic [7:0] v, exp_rx;
      int         n;
      string      tag;
      early = (md == 0 || md == 2);
      idle  = (md >= 2);
      s_early = early; s_idle = idle; exp_period = 4 * (cdm + 1);
      bus_write(A_DIV, 8'(cdm));
      bus_write(A_MODE, {3'b000, early, 1'b1, lsb, idle, loop});
      bus_write(A_TXB, tx);
      exp_q.push_back(lsb ? rev8(tx) : tx);
      slave_byte = stx;
      arm_cnt++;
      @(negedge clk);
      bus_write(A_CMD, 8'h01);
      chk(irq == 1'b0, "R8 start clears irq", irq, 0);
      if (poke) begin
         repeat (3) @(negedge clk);
         bus_write(A_TXB, ~tx);
         bus_write(A_CMD, 8'h01);
      end
      n = 0;
      while (!irq && n < 20000) begin
         @(negedge clk);
         n++;
      end
      addr = A_STAT;
      #1;
      chk(rdata[1] == 1'b1, "R7 busy still set with irq", rdata[1], 1);
      chk(rdata[0] == 1'b1, "R7 ready set with irq", rdata[0], 1);
      @(negedge clk);
      #1;
      chk(rdata[1] == 1'b0, "R7 busy cleared one cycle later", rdata[1], 0);
      chk(sck == idle, "R3 sck at idle level", sck, idle);
      if (poke) begin
         repeat (20) @(negedge clk);
         addr = A_STAT;
         #1;
         chk(rdata[1] == 1'b0, "R2 start while busy ignored", rdata[1], 0);
      end
      exp_rx = loop ? tx : (lsb ? rev8(stx) : stx);
      tag = loop ? "R6 loopback rx byte" : (lsb ? "R5 lsb-first rx byte" : "R4 mode rx byte");
      if (!keep) begin
         bus_read(A_RXB, v);
         chk(v == exp_rx, tag, v, exp_rx);
         chk(irq == 1'b0, "R8 read clears irq", irq, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R7 watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      chk(irq == 1'b0, "R9 irq after reset", irq, 0);
      chk(sck == 1'b0, "R9 sck after reset", sck, 0);
      chk(mosi == 1'b0, "R9 mosi after reset", mosi, 0);
      bus_read(A_STAT, v); chk(v == 8'h00, "R9 status after reset", v, 0);
      bus_read(A_MODE, v); chk(v == 8'h00, "R9 mode after reset", v, 0);
      bus_read(A_DIV, v);  chk(v == 8'h00, "R9 divisor after reset", v, 0);

      // R1 register access
      bus_write(A_MODE, 8'hFF);
      bus_read(A_MODE, v); chk(v == 8'h1F, "R1 mode keeps five bits", v, 8'h1F);
      bus_write(A_MODE, 8'h00);
      bus_write(A_TXB, 8'hA5);
      bus_read(A_TXB, v); chk(v == 8'hA5, "R1 send byte readback", v, 8'hA5);
      bus_write(A_DIV, 8'h3C);
      bus_read(A_DIV, v); chk(v == 8'h3C, "R1 divisor readback", v, 8'h3C);
      bus_write(A_GAP, 8'h77);
      bus_read(A_GAP, v); chk(v == 8'h00, "R1 unused offset reads zero", v, 0);
      bus_read(A_CMD, v); chk(v == 8'h00, "R1 command reads zero", v, 0);

      // R2 start with port disabled
      bus_write(A_DIV, 8'h01);
      bus_write(A_CMD, 8'h01);
      repeat (12) @(negedge clk);
      addr = A_STAT;
      #1;
      chk(rdata[1] == 1'b0, "R2 disabled start ignored", rdata[1], 0);
      chk(sck == 1'b0, "R2 no sck when disabled", sck, 0);

      // R4 all four modes, msb first
      xfer(0, 0, 0, 1, 8'hA5, 8'h3C, 0, 0);
      xfer(1, 0, 0, 1, 8'h5A, 8'hC3, 0, 0);
      xfer(2, 0, 0, 1, 8'h81, 8'h7E, 0, 0);
      xfer(3, 0, 0, 1, 8'h0F, 8'hF0, 0, 0);
      // R5 lsb first
      xfer(0, 1, 0, 1, 8'h12, 8'h34, 0, 0);
      xfer(3, 1, 0, 2, 8'hE1, 8'h96, 0, 0);
      // R6 loopback, slave drives a different byte
      xfer(1, 0, 1, 1, 8'hB7, 8'h48, 0, 0);
      xfer(2, 1, 1, 3, 8'h6C, 8'h93, 0, 0);
      // R8 leave ready set, next start must clear it
      xfer(0, 0, 0, 1, 8'h3A, 8'h5C, 0, 1);
      chk(irq == 1'b1, "R8 irq held until read", irq, 1);
      // R3 divisor 0, R2 start while busy
      xfer(1, 0, 0, 0, 8'hC9, 8'h2D, 1, 0);
      // R3 divisor 255
      xfer(3, 0, 0, 255, 8'h77, 8'h88, 0, 0);

      chk(exp_q.size() == 0, "R2 all expected bytes seen", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule